// File: doc/BRIEF.md
# Page-Mode ROM Wait-State Controller

This block sits between a processor bus and an external ROM that supports page reads, and it decides how many wait clocks each read fetch needs. The address of each new read is compared with the address of the last bus cycle the block served. When the two addresses lie in the same page, only the short page-access wait count is applied. Any other access gets the longer random-access wait count and one deselect clock. The page size is chosen at run time in powers of two, from 8 to 64 bytes. The selected size sets how many low address bits the comparison ignores.

The bus raises `req` for one clock with `addr` valid, and keeps `addr` steady until `rdy` pulses. The ROM's data is captured into `rdata` on the edge that raises `rdy`. A pulse on `other_cycle` reports that the bus ran a cycle to some other device. That pulse, and any change to the configuration inputs, makes the next read a random access.

Top module: `prw_ctrl`

## Requirements
- R1: After reset, `rom_cs`, `rom_oe` and `rdy` are low, and the first read is treated as a random access.
- R2: A read accepted while idle is on-page when the previous served read completed with no later `other_cycle` or configuration change, and the address bits above the page offset match. `rdy` then rises on the (`cfg_page_wait`+1)-th rising edge after the accepting edge.
- R3: Every other accepted read is off-page. `rom_cs` and `rom_oe` are low for the one clock after the accepting edge, and `rdy` rises on the (`cfg_norm_wait`+2)-th rising edge after the accepting edge.
- R4: The encoding of `cfg_page_sel` is 0 for 8 bytes, 1 for 16, 2 for 32 and 3 for 64. The comparison ignores address bits [2:0], [3:0], [4:0] or [5:0] respectively.
- R5: An `other_cycle` pulse while idle drops `rom_cs` and `rom_oe` on the next edge, and forces the next read off-page.
- R6: A change of any configuration input drops `rom_cs` and `rom_oe` on the next edge while idle, and forces the next read off-page. This includes a read accepted in the same clock as the change.
- R7: `rom_cs` and `rom_oe` stay high through an on-page access and through the idle clocks after a completed read, until R5 or R6 drops them.
- R8: `rdy` is high for exactly one clock. `rdata` then holds the value that `rom_data_i` had in the clock before `rdy` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-clock read request, taken only while idle |
| addr | input | AW | Read byte address, held until `rdy` |
| other_cycle | input | 1 | Pulse: the bus served a non-ROM cycle |
| cfg_page_sel | input | 2 | Page size select (0:8 B, 1:16 B, 2:32 B, 3:64 B) |
| cfg_norm_wait | input | WW | Wait clocks for an off-page read |
| cfg_page_wait | input | WW | Wait clocks for an on-page read |
| rom_data_i | input | DW | Data from the ROM |
| rom_cs | output | 1 | ROM chip select, active high |
| rom_oe | output | 1 | ROM output enable, active high |
| rdy | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |

## Verification
Every result is timed from the edge that accepts `req`. The deselect of an off-page read, or the held select of an on-page read, appears right after that edge. `rdy` arrives one edge after the wait count expires for an on-page read, and two edges after it for an off-page read. The effect of a `other_cycle` pulse or a configuration change on `rom_cs` shows one edge later. The bench drives on falling edges and counts the falling edges that follow the accepting edge. It expects `rdy` at count `cfg_page_wait`+2 or `cfg_norm_wait`+3, and reads the select state at count 1. A reference model of the page comparison decides which count applies.

// File: rtl/prw_pkg.sv
package prw_pkg;

    // Smallest page is 8 bytes: 3 offset bits always ignored.
    localparam int MIN_PAGE_LG = 3;
    localparam int SEL_W       = 2;
    localparam int MAX_PAGE_LG = MIN_PAGE_LG + (1 << SEL_W) - 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DESEL = 2'd1,
        ST_WAIT  = 2'd2
    } prw_state_e;

    function automatic int offset_bits(input logic [SEL_W-1:0] sel);
        return MIN_PAGE_LG + int'(sel);
    endfunction

endpackage

// File: rtl/prw_page_cmp.sv
module prw_page_cmp
    import prw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    a,
    input  logic [AW-1:0]    b,
    input  logic [SEL_W-1:0] sel,
    output logic             same_page
);

    logic [AW-1:0] care;
    logic [AW-1:0] diff;

    generate
        for (genvar i = 0; i < AW; i++) begin : g_care
            if (i < MIN_PAGE_LG) begin : g_off
                assign care[i] = 1'b0;
            end else begin : g_tag
                assign care[i] = (i >= offset_bits(sel));
            end
        end
    endgenerate

    assign diff      = (a ^ b) & care;
    assign same_page = ~|diff;

    // R4: a page hit never spans the widest page boundary
    always_comb begin
        if (same_page) begin
            assert_tag_match_R4: assert (a[AW-1:MAX_PAGE_LG] == b[AW-1:MAX_PAGE_LG]);
        end
    end

endmodule

// File: rtl/prw_cfg_watch.sv
module prw_cfg_watch #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cfg,
    output logic         chg
);

    logic [W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign chg = (cfg != cfg_q);

endmodule

// File: rtl/prw_ctrl.sv
module prw_ctrl
    import prw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int WW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [AW-1:0]    addr,
    input  logic             other_cycle,
    input  logic [SEL_W-1:0] cfg_page_sel,
    input  logic [WW-1:0]    cfg_norm_wait,
    input  logic [WW-1:0]    cfg_page_wait,
    input  logic [DW-1:0]    rom_data_i,
    output logic             rom_cs,
    output logic             rom_oe,
    output logic             rdy,
    output logic [DW-1:0]    rdata
);

    localparam int CFG_W = SEL_W + 2 * WW;

    typedef struct packed {
        prw_state_e       st;
        logic [WW-1:0]    cnt;
        logic [AW-1:0]    cur;
        logic [AW-1:0]    prev;
        logic             valid;
        logic             stale;
        logic             cs;
        logic             oe;
        logic             rdy;
        logic [DW-1:0]    data;
    } regs_t;

    regs_t r_d, r_q;

    logic cfg_chg;
    logic tag_hit;
    logic hit_eff;
    logic kill;

    prw_cfg_watch #(.W(CFG_W)) u_cfg_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   ({cfg_page_sel, cfg_norm_wait, cfg_page_wait}),
        .chg   (cfg_chg)
    );

    prw_page_cmp #(.AW(AW)) u_page_cmp (
        .a         (addr),
        .b         (r_q.prev),
        .sel       (cfg_page_sel),
        .same_page (tag_hit)
    );

    assign kill    = other_cycle | cfg_chg;
    assign hit_eff = r_q.valid & ~kill & tag_hit;

    always_comb begin
        r_d     = r_q;
        r_d.rdy = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (kill) r_d.valid = 1'b0;
                if (req) begin
                    r_d.cur   = addr;
                    r_d.stale = 1'b0;
                    if (hit_eff) begin
                        r_d.cnt = cfg_page_wait;
                        r_d.st  = ST_WAIT;
                    end else begin
                        r_d.cnt   = cfg_norm_wait;
                        r_d.st    = ST_DESEL;
                        r_d.valid = 1'b0;
                    end
                end
            end
            ST_DESEL: begin
                if (kill) r_d.stale = 1'b1;
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (kill) r_d.stale = 1'b1;
                if (r_q.cnt == '0) begin
                    r_d.rdy   = 1'b1;
                    r_d.data  = rom_data_i;
                    r_d.prev  = r_q.cur;
                    r_d.valid = ~(r_q.stale | kill);
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.cs = (r_d.st == ST_WAIT) || (r_d.st == ST_IDLE && r_d.valid);
        r_d.oe = r_d.cs;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q       <= r_d;
        end
    end

    assign rom_cs = r_q.cs;
    assign rom_oe = r_q.oe;
    assign rdy    = r_q.rdy;
    assign rdata  = r_q.data;

    assert_rdy_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    assert_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> rdata == $past(rom_data_i));

    assert_offpage_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && req && !hit_eff) |=> (!rom_cs && !rom_oe));

    assert_onpage_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && req && hit_eff) |=> (rom_cs && rom_oe));

    assert_other_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && other_cycle && !req) |=> !rom_cs);

    assert_cfg_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && cfg_chg && !req) |=> !rom_cs);

    assert_rdy_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> $past(rom_cs));

endmodule

// File: tb/prw_ctrl_bench.sv
module prw_ctrl_bench;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req;
    logic [AW-1:0] addr;
    logic          other_cycle;
    logic [1:0]    cfg_page_sel;
    logic [WW-1:0] cfg_norm_wait;
    logic [WW-1:0] cfg_page_wait;
    logic [DW-1:0] rom_data_i;
    logic          rom_cs, rom_oe, rdy;
    logic [DW-1:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [AW-1:0] m_prev;
    bit            m_valid;

    always #10 clk = ~clk;

    prw_ctrl #(.AW(AW), .DW(DW), .WW(WW)) u_prw_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr),
        .other_cycle(other_cycle), .cfg_page_sel(cfg_page_sel),
        .cfg_norm_wait(cfg_norm_wait), .cfg_page_wait(cfg_page_wait),
        .rom_data_i(rom_data_i), .rom_cs(rom_cs), .rom_oe(rom_oe),
        .rdy(rdy), .rdata(rdata)
    );

    function automatic logic [DW-1:0] rom_val(input logic [AW-1:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    assign rom_data_i = rom_val(addr);

    function automatic bit exp_hit(input logic [AW-1:0] a, input logic [AW-1:0] p,
                                   input bit v, input logic [1:0] sel);
        int sh = 3 + int'(sel);
        return v && ((a >> sh) == (p >> sh));
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] sel, input logic [WW-1:0] nw, input logic [WW-1:0] pw);
        if (sel != cfg_page_sel || nw != cfg_norm_wait || pw != cfg_page_wait) m_valid = 0;
        cfg_page_sel  = sel;
        cfg_norm_wait = nw;
        cfg_page_wait = pw;
    endtask

    // Called at a falling edge while idle.
    task automatic access(input logic [AW-1:0] a);
        bit hit = exp_hit(a, m_prev, m_valid, cfg_page_sel);
        int lat = hit ? int'(cfg_page_wait) + 2 : int'(cfg_norm_wait) + 3;
        int n;
        req  = 1'b1;
        addr = a;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        n   = 1;
        if (hit) check(rom_cs && rom_oe, "R7 select held on-page", rom_cs, 1);
        else     check(!rom_cs && !rom_oe, "R3 deselect clock off-page", rom_cs, 0);
        while (!rdy && n < 40) begin
            @(negedge clk);
            n++;
        end
        if (hit) check(n == lat, "R2 on-page latency", n, lat);
        else     check(n == lat, "R3 off-page latency", n, lat);
        check(rdata == rom_val(a), "R8 captured data", rdata, rom_val(a));
        check(rom_cs && rom_oe, "R7 select held after ready", rom_cs, 1);
        @(negedge clk);
        check(!rdy, "R8 ready one clock", rdy, 0);
        m_prev  = a;
        m_valid = 1;
    endtask

    task automatic pulse_other();
        other_cycle = 1'b1;
        @(negedge clk);
        other_cycle = 1'b0;
        check(!rom_cs && !rom_oe, "R5 select drops after other cycle", rom_cs, 0);
        m_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; req = 1'b0; addr = '0; other_cycle = 1'b0;
        cfg_page_sel = 2'd1; cfg_norm_wait = 4'd5; cfg_page_wait = 4'd1;
        m_prev = '0; m_valid = 0;
        repeat (3) @(negedge clk);
        check(!rom_cs && !rom_oe && !rdy, "R1 reset outputs", {rom_cs, rom_oe, rdy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);

        // R1: first read off-page even though address 0 matches reset prev
        access(32'h0000_0000);
        access(32'h0000_0004);
        // R4: 16-byte page
        access(32'h0000_000F);
        access(32'h0000_0010);
        // R4: 8-byte page boundary
        set_cfg(2'd0, 4'd3, 4'd0);
        @(negedge clk);
        check(!rom_cs, "R6 select drops after config change", rom_cs, 0);
        access(32'h0000_0100);
        access(32'h0000_0107);
        access(32'h0000_0108);
        // R4: 64-byte page
        set_cfg(2'd3, 4'd0, 4'd2);
        @(negedge clk);
        access(32'h0000_1000);
        access(32'h0000_103F);
        access(32'h0000_1040);
        // R5: other cycle forces off-page
        pulse_other();
        access(32'h0000_1044);
        // R6: change in the same clock as request
        set_cfg(2'd3, 4'd7, 4'd2);
        access(32'h0000_1048);
        // R7: idle hold
        repeat (3) @(negedge clk);
        check(rom_cs && rom_oe, "R7 select held while idle", rom_cs, 1);
        // Extreme waits
        set_cfg(2'd2, 4'd15, 4'd15);
        access(32'h0000_2000);
        access(32'h0000_201C);

        for (int it = 0; it < 400; it++) begin
            int r = int'($urandom % 10);
            if (r == 0) begin
                pulse_other();
            end else if (r == 1) begin
                set_cfg(2'($urandom), 4'($urandom), 4'($urandom));
                if ($urandom % 2 == 0) @(negedge clk);
            end else if (r == 2) begin
                repeat (2) @(negedge clk);
                check(rom_cs == m_valid, "R7 idle select state", rom_cs, m_valid);
            end else begin
                logic [AW-1:0] na;
                if ($urandom % 4 == 0) na = $urandom;
                else na = m_prev + AW'($urandom % 80) - AW'(16);
                access(na);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule